// File: doc/BRIEF.md
# Combined program counter and status word

This block is a single 32-bit architectural register that carries a word-aligned program counter alongside the arithmetic condition flags, two interrupt-disable bits and a two-bit processor mode. The datapath sees it through two read ports. The first-operand view exposes only the program counter field. The second-operand view exposes the whole word, so software can inspect the flags and the mode.

Three independent write paths update the register. The fetch unit uses a PC-only write for sequential fetch and branches. The ALU uses a flag write, qualified by a set-flags strobe, to update the four condition flags. A masked status write copies the flag, mask and mode bits of a result word into the register. This write never touches the program counter, and it is limited by the privilege of the mode that is current when the write happens.

Top module: `pcsr_reg`

## Requirements
- R1: The full word is laid out as follows: N at bit 31, Z at bit 30, C at bit 29, V at bit 28, the slow-interrupt disable at bit 27, the fast-interrupt disable at bit 26, the program counter at bits 25..2 and the mode at bits 1..0. The second-operand port returns all 32 bits.
- R2: After reset, mode is 2'b11 (supervisor), both interrupt-disable bits are 1, the flags are 0 and the PC is 0, so the second-operand port reads 32'h0C00_0003.
- R3: The first-operand port returns the PC field at bits 25..2 with every other bit zero.
- R4: A PC write (`pc_we`) replaces bits 25..2 with `pc_in` in the next cycle and leaves bits 31..26 and 1..0 unchanged.
- R5: A flag write (`flg_we`) places `flg_in` (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V) into bits 31..28 and changes no other bit.
- R6: In a privileged mode (2'b01 fast interrupt, 2'b10 interrupt, 2'b11 supervisor), a status write (`st_we`) copies `st_src` bits 31..26 and 1..0 into the same positions and leaves the PC unchanged.
- R7: In user mode (2'b00), a status write changes only bits 31..28. Bits 27..26 and 1..0 keep their values. Privilege is judged by the mode held before the write.
- R8: A status write and a PC write in the same cycle both take effect, each on its own fields.
- R9: When a status write and a flag write occur in the same cycle, the status write sets bits 31..28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_we | input | 1 | PC-only write enable |
| pc_in | input | 24 | New word-address PC value |
| flg_we | input | 1 | ALU set-flags strobe |
| flg_in | input | 4 | New N, Z, C, V (bits 3..0) |
| st_we | input | 1 | Masked status write enable |
| st_src | input | 32 | Source word for the status write |
| opa_rd | output | 32 | First-operand view: PC field only |
| opb_rd | output | 32 | Second-operand view: full word |

## Verification
The status write is tested with all-ones and with sparse source words, in supervisor mode, in the fast-interrupt mode and in user mode. Comparing these cases separates the privileged mask from the user mask. It also shows that the PC bits of the source are always dropped. Writes are also issued in collision pairs (status with PC, and status with flags) and compared with single writes, which shows both that the fields are independent and that the status write wins on the flags. A second reset in the middle of the run checks that supervisor privilege is restored after a stay in user mode.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;

  localparam int PC_W_DEF = 24;
  localparam int FLAG_N   = 4;
  localparam int IMSK_N   = 2;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } mode_e;

  function automatic logic is_priv(input logic [MODE_W-1:0] m);
    return (m != MODE_USR);
  endfunction

endpackage

// File: rtl/pcsr_priv_mask.sv
module pcsr_priv_mask
  import pcsr_pkg::*;
#(
  parameter int PC_W = PC_W_DEF,
  localparam int XLEN = PC_W + FLAG_N + IMSK_N + MODE_W
) (
  input  logic [MODE_W-1:0] cur_mode,
  output logic [XLEN-1:0]   st_mask,
  output logic              priv_now
);

  localparam int IMSK_HI = XLEN - FLAG_N - 1;

  function automatic logic [XLEN-1:0] build_mask(input logic priv);
    logic [XLEN-1:0] m;
    m = '0;
    m[XLEN-1 -: FLAG_N] = '1;
    if (priv) begin
      m[IMSK_HI -: IMSK_N] = '1;
      m[MODE_W-1:0]        = '1;
    end
    return m;
  endfunction

  assign priv_now = is_priv(cur_mode);
  assign st_mask  = build_mask(priv_now);

endmodule

// File: rtl/pcsr_next.sv
module pcsr_next
  import pcsr_pkg::*;
#(
  parameter int PC_W = PC_W_DEF,
  localparam int XLEN = PC_W + FLAG_N + IMSK_N + MODE_W
) (
  input  logic [XLEN-1:0]   cur,
  input  logic [XLEN-1:0]   st_mask,
  input  logic              pc_we,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              flg_we,
  input  logic [FLAG_N-1:0] flg_in,
  input  logic              st_we,
  input  logic [XLEN-1:0]   st_src,
  output logic [XLEN-1:0]   nxt
);

  localparam int PC_LO = MODE_W;

  function automatic logic [XLEN-1:0] merge_masked(input logic [XLEN-1:0] old_w,
                                                    input logic [XLEN-1:0] src_w,
                                                    input logic [XLEN-1:0] msk);
    return (old_w & ~msk) | (src_w & msk);
  endfunction

  logic [XLEN-1:0] after_flg;
  logic [XLEN-1:0] after_st;

  always_comb begin
    after_flg = cur;
    if (flg_we) after_flg[XLEN-1 -: FLAG_N] = flg_in;
  end

  assign after_st = st_we ? merge_masked(after_flg, st_src, st_mask) : after_flg;

  always_comb begin
    nxt = after_st;
    if (pc_we) nxt[PC_LO +: PC_W] = pc_in;
  end

endmodule

// File: rtl/pcsr_reg.sv
module pcsr_reg
  import pcsr_pkg::*;
#(
  parameter int PC_W = PC_W_DEF,
  localparam int XLEN = PC_W + FLAG_N + IMSK_N + MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_we,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              flg_we,
  input  logic [FLAG_N-1:0] flg_in,
  input  logic              st_we,
  input  logic [XLEN-1:0]   st_src,
  output logic [XLEN-1:0]   opa_rd,
  output logic [XLEN-1:0]   opb_rd
);

  localparam int PC_LO   = MODE_W;
  localparam int IMSK_LO = PC_LO + PC_W;

  function automatic logic [XLEN-1:0] reset_word();
    logic [XLEN-1:0] w;
    w = '0;
    w[IMSK_LO +: IMSK_N] = '1;
    w[MODE_W-1:0]        = MODE_SVC;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] pc_view(input logic [XLEN-1:0] w);
    logic [XLEN-1:0] v;
    v = '0;
    v[PC_LO +: PC_W] = w[PC_LO +: PC_W];
    return v;
  endfunction

  logic [XLEN-1:0]   word_q;
  logic [XLEN-1:0]   word_d;
  logic [XLEN-1:0]   st_mask;
  logic              priv_now;
  logic [MODE_W-1:0] cur_mode;

  assign cur_mode = word_q[MODE_W-1:0];

  pcsr_priv_mask #(.PC_W(PC_W)) u_mask (
    .cur_mode (cur_mode),
    .st_mask  (st_mask),
    .priv_now (priv_now)
  );

  pcsr_next #(.PC_W(PC_W)) u_next (
    .cur     (word_q),
    .st_mask (st_mask),
    .pc_we   (pc_we),
    .pc_in   (pc_in),
    .flg_we  (flg_we),
    .flg_in  (flg_in),
    .st_we   (st_we),
    .st_src  (st_src),
    .nxt     (word_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= reset_word();
    else        word_q <= word_d;
  end

  assign opb_rd = word_q;
  assign opa_rd = pc_view(word_q);

endmodule

// File: rtl/pcsr_chk.sv
module pcsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_we,
  input logic        flg_we,
  input logic [3:0]  flg_in,
  input logic        st_we,
  input logic [31:0] st_src,
  input logic        priv_now,
  input logic [31:0] opa_rd,
  input logic [31:0] opb_rd
);

  AST_OPA_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    opa_rd == (opb_rd & 32'h03FF_FFFC)); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> opb_rd[25:2] == $past(opb_rd[25:2])); // R4

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flg_we && !st_we) |=> opb_rd[31:28] == $past(opb_rd[31:28])); // R5

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && !st_we) |=> opb_rd[31:28] == $past(flg_in)); // R5

  AST_PRIV_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && priv_now) |=> (opb_rd[31:26] == $past(st_src[31:26]))
                            && (opb_rd[1:0] == $past(st_src[1:0]))); // R6

  AST_USER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && (opb_rd[1:0] == 2'b00)) |=> (opb_rd[27:26] == $past(opb_rd[27:26]))
                                          && (opb_rd[1:0] == 2'b00)); // R7

  AST_ST_OVER_FLG: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> opb_rd[31:28] == $past(st_src[31:28])); // R9

endmodule

bind pcsr_reg pcsr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc_we    (pc_we),
  .flg_we   (flg_we),
  .flg_in   (flg_in),
  .st_we    (st_we),
  .st_src   (st_src),
  .priv_now (priv_now),
  .opa_rd   (opa_rd),
  .opb_rd   (opb_rd)
);

// File: tb/pcsr_reg_tb.sv
module pcsr_reg_tb_top;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_we = 1'b0;
  logic [23:0] pc_in = '0;
  logic        flg_we = 1'b0;
  logic [3:0]  flg_in = '0;
  logic        st_we = 1'b0;
  logic [31:0] st_src = '0;
  logic [31:0] opa_rd;
  logic [31:0] opb_rd;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = 32'h0C00_0003;
  item_t sb_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcsr_reg dut_i (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_in(pc_in),
    .flg_we(flg_we), .flg_in(flg_in), .st_we(st_we), .st_src(st_src),
    .opa_rd(opa_rd), .opb_rd(opb_rd)
  );

  task automatic compare(input logic [31:0] exp, input string tag);
    checks++;
    if (opb_rd !== exp) begin
      errors++;
      $display("FAIL %s opb actual=%h expected=%h", tag, opb_rd, exp);
    end
    checks++;
    if (opa_rd !== (exp & 32'h03FF_FFFC)) begin
      errors++;
      $display("FAIL %s/R3 opa actual=%h expected=%h", tag, opa_rd, exp & 32'h03FF_FFFC);
    end
  endtask

  // driver: applies one cycle of writes and pushes the expected word
  task automatic drive(input bit pw, input logic [23:0] pv, input bit fw,
                       input logic [3:0] fv, input bit sw, input logic [31:0] sv,
                       input string tag);
    logic [31:0] msk;
    @(negedge clk);
    pc_we = pw; pc_in = pv; flg_we = fw; flg_in = fv; st_we = sw; st_src = sv;
    msk = (model[1:0] != 2'b00) ? 32'hFC00_0003 : 32'hF000_0000;
    if (fw) model[31:28] = fv;
    if (sw) model = (model & ~msk) | (sv & msk);
    if (pw) model[25:2] = pv;
    sb_q.push_back('{exp: model, tag: tag});
  endtask

  task automatic do_reset();
    @(negedge clk);
    pc_we = 0; flg_we = 0; st_we = 0;
    rst_n = 1'b0;
    model = 32'h0C00_0003;
    #1;
    compare(32'h0C00_0003, "R2 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        compare(it.exp, it.tag);
      end
    end
  end

  initial begin
    do_reset();
    drive(1, 24'h123456, 0, 0, 0, 0, "R4 pc write");
    drive(0, 0, 0, 0, 0, 0, "R1 idle hold");
    drive(0, 0, 1, 4'hA, 0, 0, "R5 flag write");
    drive(1, 24'h000001, 1, 4'h5, 0, 0, "R5 flag with pc");
    drive(0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R6 svc all-ones");
    drive(0, 0, 0, 0, 1, 32'h4400_0001, "R6 to fiq");
    drive(0, 0, 0, 0, 1, 32'h9800_0000, "R6 fiq to user");
    drive(0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R7 user all-ones");
    drive(0, 0, 0, 0, 1, 32'h3C00_0003, "R7 user mode escape");
    drive(1, 24'hABCDEF, 0, 0, 1, 32'h5000_0000, "R8 user st+pc");
    drive(0, 0, 1, 4'hF, 1, 32'h2000_0000, "R9 user st+flg");
    do_reset();
    drive(1, 24'hFFFFFF, 0, 0, 1, 32'hA000_0002, "R8 svc st+pc");
    drive(0, 0, 1, 4'h0, 1, 32'hC400_0002, "R9 irq st+flg");
    drive(0, 0, 0, 0, 1, 32'h0000_0003, "R6 irq to svc");
    drive(1, 24'h000000, 0, 0, 0, 0, "R4 pc clear");
    drive(0, 0, 0, 0, 0, 0, "R1 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule